// File: doc/BRIEF.md
# GPIO Interrupt Event Detector

This block turns activity on a bank of general-purpose pins into a single interrupt request. It takes the current logic level of each pin, a per-pin flag that says whether the pin is driven as an output, and a per-pin strobe that pulses when the sampled level of that pin has just changed. Each pin is set to one of two modes. In level mode it raises its status whenever its level matches a polarity bit. In edge mode it raises its status on a change, either on any change or only on the change that lands on the selected polarity.

Software sets up the block through a small register window. There are four control registers: mode, any-change enable, polarity and enable mask. There are two read-only views of the status: raw and masked. A write-one-to-clear port acknowledges events. Status bits are sticky. A level-mode pin sets its bit again on every cycle, so a clear has no lasting effect while its condition holds. The interrupt line is registered and goes high while any enabled status bit is set.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, all control registers, the raw status and the masked status read as 0 and `irq` is 0.
- R2: The mode (offset 0x404, bit=1 selects level mode), any-change (0x408), polarity (0x40C) and enable-mask (0x410) registers each read back the last value written to them. A register that is not written keeps its value.
- R3: An edge-mode pin whose any-change bit is 1, and whose output flag is 0, sets its raw status bit in the cycle its change strobe is high.
- R4: An edge-mode pin whose any-change bit is 0 sets its raw bit on a strobe only when its new level equals its polarity bit (1 = rising, 0 = falling).
- R5: A change strobe on an edge-mode pin whose output flag is 1 never sets its raw bit.
- R6: A level-mode pin sets its raw bit in every cycle in which its level equals its polarity bit, with or without a strobe. While that holds, a clear leaves the bit set.
- R7: Writing the clear port (0x41C) clears each raw bit written as 1. Bits written as 0 are left unchanged.
- R8: If a set condition and a clear of the same bit fall in one cycle, the bit ends up set.
- R9: Offset 0x414 returns the raw status and 0x418 returns the raw status ANDed with the mask. Writes to these two offsets have no effect.
- R10: `irq` is registered. It rises one cycle after a masked bit becomes 1, and falls one cycle after the last masked bit becomes 0.
- R11: Reads from any offset outside the register window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| pin_level | input | NPINS | Current sampled level of each pin |
| pin_is_out | input | NPINS | 1 where the pin is driven as an output |
| pin_chg | input | NPINS | One-cycle strobe per pin on a sampled level change |
| irq | output | 1 | Interrupt request, registered |

## Verification
The bench builds the block with the default width of eight pins. With eight pins, a single vector can put level-mode, any-change, single-polarity and output-flagged pins side by side in one setup, and every bit position of the status can be checked at once. At this width, all-ones patterns and mixed patterns can be written to the clear port, which covers both the bits that are cleared and the bits that are left alone.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned REG_AW = 12;

    localparam logic [REG_AW-1:0] OFS_MODE   = 12'h404;
    localparam logic [REG_AW-1:0] OFS_ANYCHG = 12'h408;
    localparam logic [REG_AW-1:0] OFS_POLAR  = 12'h40C;
    localparam logic [REG_AW-1:0] OFS_ENMASK = 12'h410;
    localparam logic [REG_AW-1:0] OFS_RAW    = 12'h414;
    localparam logic [REG_AW-1:0] OFS_MASKED = 12'h418;
    localparam logic [REG_AW-1:0] OFS_ACK    = 12'h41C;

endpackage

// File: rtl/gpio_irq_pin_cell.sv
module gpio_irq_pin_cell (
    input  logic lvl,
    input  logic is_out,
    input  logic chg,
    input  logic mode_level,
    input  logic any_chg,
    input  logic polar,
    output logic set_req
);
    logic match;

    always_comb begin
        match = (lvl == polar);
        if (mode_level) begin
            set_req = match;
        end else begin
            set_req = chg & ~is_out & (any_chg | match);
        end
    end
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  set_vec,
    output logic [NPINS-1:0]  mode_q,
    output logic [NPINS-1:0]  anychg_q,
    output logic [NPINS-1:0]  polar_q,
    output logic [NPINS-1:0]  enmask_q,
    output logic [NPINS-1:0]  raw_q,
    output logic              irq_q
);
    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] anychg;
        logic [NPINS-1:0] polar;
        logic [NPINS-1:0] enmask;
        logic [NPINS-1:0] raw;
        logic             irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_MODE:   st_d.mode   = bus_wdata;
                OFS_ANYCHG: st_d.anychg = bus_wdata;
                OFS_POLAR:  st_d.polar  = bus_wdata;
                OFS_ENMASK: st_d.enmask = bus_wdata;
                OFS_ACK:    st_d.raw    = st_q.raw & ~bus_wdata;
                default:    ;
            endcase
        end
        // new events are merged after the acknowledge so they are never dropped
        st_d.raw = st_d.raw | set_vec;
        st_d.irq = |(st_q.raw & st_q.enmask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_MODE:   bus_rdata = st_q.mode;
            OFS_ANYCHG: bus_rdata = st_q.anychg;
            OFS_POLAR:  bus_rdata = st_q.polar;
            OFS_ENMASK: bus_rdata = st_q.enmask;
            OFS_RAW:    bus_rdata = st_q.raw;
            OFS_MASKED: bus_rdata = st_q.raw & st_q.enmask;
            default:    bus_rdata = '0;
        endcase
    end

    assign mode_q   = st_q.mode;
    assign anychg_q = st_q.anychg;
    assign polar_q  = st_q.polar;
    assign enmask_q = st_q.enmask;
    assign raw_q    = st_q.raw;
    assign irq_q    = st_q.irq;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_level,
    input  logic [NPINS-1:0]  pin_is_out,
    input  logic [NPINS-1:0]  pin_chg,
    output logic              irq
);
    logic [NPINS-1:0] set_vec;
    logic [NPINS-1:0] mode_st;
    logic [NPINS-1:0] anychg_st;
    logic [NPINS-1:0] polar_st;
    logic [NPINS-1:0] mask_st;
    logic [NPINS-1:0] raw_st;

    for (genvar gi = 0; gi < NPINS; gi++) begin : g_pin
        gpio_irq_pin_cell u_cell (
            .lvl        (pin_level[gi]),
            .is_out     (pin_is_out[gi]),
            .chg        (pin_chg[gi]),
            .mode_level (mode_st[gi]),
            .any_chg    (anychg_st[gi]),
            .polar      (polar_st[gi]),
            .set_req    (set_vec[gi])
        );
    end

    gpio_irq_regs #(.NPINS(NPINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .set_vec   (set_vec),
        .mode_q    (mode_st),
        .anychg_q  (anychg_st),
        .polar_q   (polar_st),
        .enmask_q  (mask_st),
        .raw_q     (raw_st),
        .irq_q     (irq)
    );
endmodule

// File: rtl/gpio_irq_checker.sv
module gpio_irq_checker
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NPINS = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pin_is_out,
    input logic [NPINS-1:0]  set_vec,
    input logic [NPINS-1:0]  mode,
    input logic [NPINS-1:0]  raw,
    input logic [NPINS-1:0]  mask,
    input logic              irq
);
    AST_IRQ_ONE_CYCLE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|(raw & mask))); // R10

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((raw & $past(set_vec)) == $past(set_vec))); // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_ACK) |=> ((raw & $past(bus_wdata & ~set_vec)) == '0)); // R7

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw & ~$past(raw) & ~$past(set_vec)) == '0)); // R9

    AST_OUTPUT_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec & pin_is_out & ~mode) == '0); // R5

    AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_MODE) |=> $stable(mode)); // R2
endmodule

bind gpio_irq_detect gpio_irq_checker #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .pin_is_out (pin_is_out),
    .set_vec    (set_vec),
    .mode       (mode_st),
    .raw        (raw_st),
    .mask       (mask_st),
    .irq        (irq)
);

// File: tb/tb_gpio_irq_detect.sv
`timescale 1ns/1ps
module tb_gpio_irq_detect;
    import gpio_irq_pkg::*;

    localparam int unsigned N = 8;
    localparam int unsigned NVEC = 5;

    // fields: mode, anychg, polar, is_out, level_before, level_after, strobe, expected raw
    localparam logic [63:0] VEC [NVEC] = '{
        64'h00_FF_00_00_00_0F_FF_FF,   // R3 any change on every input pin
        64'h00_00_F0_00_00_3C_FF_33,   // R4 polarity-selected edges
        64'h00_FF_00_0F_00_FF_FF_F0,   // R5 output-flagged pins ignore strobes
        64'h0F_00_05_00_00_00_00_0A,   // R6 level pins without strobes
        64'h F0_0C_A0_01_00_6E_0F_7C    // R6 R4 R5 mixed bank
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [N-1:0]  bus_wdata = '0;
    logic [N-1:0]  bus_rdata;
    logic [N-1:0]  pin_level = '0;
    logic [N-1:0]  pin_is_out = '0;
    logic [N-1:0]  pin_chg = '0;
    logic          irq;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gpio_irq_detect #(.NPINS(N)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .pin_level  (pin_level),
        .pin_is_out (pin_is_out),
        .pin_chg    (pin_chg),
        .irq        (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [N-1:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [11:0] a, input logic [N-1:0] exp);
        bus_addr = a;
        #1;
        check(req, 32'(bus_rdata), 32'(exp));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", 32'(irq), 0);
        rd_check("R1 mode", OFS_MODE, 8'h00);
        rd_check("R1 anychg", OFS_ANYCHG, 8'h00);
        rd_check("R1 polar", OFS_POLAR, 8'h00);
        rd_check("R1 mask", OFS_ENMASK, 8'h00);
        rd_check("R1 raw", OFS_RAW, 8'h00);
        rd_check("R1 masked", OFS_MASKED, 8'h00);
        @(negedge clk);

        // R2 read-back
        wr(OFS_MODE, 8'hA5);
        wr(OFS_ANYCHG, 8'h5A);
        wr(OFS_POLAR, 8'h3C);
        wr(OFS_ENMASK, 8'hC3);
        rd_check("R2 mode", OFS_MODE, 8'hA5);
        rd_check("R2 anychg", OFS_ANYCHG, 8'h5A);
        rd_check("R2 polar", OFS_POLAR, 8'h3C);
        rd_check("R2 mask", OFS_ENMASK, 8'hC3);
        @(negedge clk);
        wr(OFS_ENMASK, 8'h00);

        // R11 unmapped offsets
        rd_check("R11 0x420", 12'h420, 8'h00);
        rd_check("R11 0x000", 12'h000, 8'h00);
        @(negedge clk);

        // table of configurations
        for (int v = 0; v < NVEC; v++) begin
            wr(OFS_MODE, VEC[v][63:56]);
            wr(OFS_ANYCHG, VEC[v][55:48]);
            wr(OFS_POLAR, VEC[v][47:40]);
            pin_is_out = VEC[v][39:32];
            pin_level = VEC[v][31:24];
            @(negedge clk);
            wr(OFS_ACK, 8'hFF);
            pin_level = VEC[v][23:16];
            pin_chg = VEC[v][15:8];
            @(negedge clk);
            pin_chg = '0;
            rd_check($sformatf("R3 R4 R5 R6 vector %0d", v), OFS_RAW, VEC[v][7:0]);
            @(negedge clk);
        end

        // clean setup: all edge mode, any change, inputs
        wr(OFS_MODE, 8'h00);
        wr(OFS_ANYCHG, 8'hFF);
        wr(OFS_POLAR, 8'h00);
        pin_is_out = '0;
        pin_level = '0;
        wr(OFS_ACK, 8'hFF);
        rd_check("R7 all cleared", OFS_RAW, 8'h00);

        // R9 read-only status offsets
        wr(OFS_RAW, 8'hFF);
        wr(OFS_MASKED, 8'hFF);
        rd_check("R9 raw write ignored", OFS_RAW, 8'h00);

        pin_chg = 8'h05;
        @(negedge clk);
        pin_chg = '0;
        rd_check("R3 raw after strobe", OFS_RAW, 8'h05);
        check("R10 irq masked off", 32'(irq), 0);

        // R10 registered interrupt
        wr(OFS_ENMASK, 8'h04);
        check("R10 irq not yet", 32'(irq), 0);
        @(negedge clk);
        check("R10 irq raised", 32'(irq), 1);
        rd_check("R9 masked view", OFS_MASKED, 8'h04);

        // R7 selective clear
        wr(OFS_ACK, 8'h01);
        rd_check("R7 partial clear", OFS_RAW, 8'h04);
        check("R10 irq still high", 32'(irq), 1);
        wr(OFS_ACK, 8'h04);
        rd_check("R7 bit cleared", OFS_RAW, 8'h00);
        check("R10 irq lag on fall", 32'(irq), 1);
        @(negedge clk);
        check("R10 irq dropped", 32'(irq), 0);

        // R8 set and clear in one cycle
        pin_chg = 8'h02;
        wr(OFS_ACK, 8'h02);
        pin_chg = '0;
        rd_check("R8 set wins", OFS_RAW, 8'h02);
        wr(OFS_ACK, 8'h02);

        // R6 level pin cannot be cleared while its condition holds
        wr(OFS_MODE, 8'h80);
        @(negedge clk);
        wr(OFS_ACK, 8'h80);
        rd_check("R6 level bit persists", OFS_RAW, 8'h80);
        pin_level = 8'h80;
        wr(OFS_ACK, 8'h80);
        rd_check("R6 level bit cleared", OFS_RAW, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule